// File: doc/BRIEF.md
# Descriptor Queue Controller

This block walks a ring of command descriptors that software builds in memory. Four address registers describe the ring: the lowest entry address, the highest entry address, the next entry to run (the read pointer) and the position where software will write the next entry (the write pointer). Software adds work by writing 64-byte entries and moving the write pointer forward one entry at a time. It then sets the enable bit in the control/status register. From that point the controller reads each entry through a request/response port, one word per beat. It presents the entry's control word, source address and destination address to an execution unit and waits for that unit to signal completion. It then moves the read pointer on, and it goes idle when the read pointer meets the write pointer.

Each control word can ask for a completion interrupt aimed at one of eight strands. The controller also records whether it is running, whether software stopped it part way, and whether it met a ring pointer that was not aligned to an entry. The execution unit is outside the block. Only its handshake is modelled here.

Top module: `dq_ctrl`

## Requirements
- R1: The register port selects, by `reg_sel`, 0 = lowest entry address, 1 = highest entry address, 2 = read pointer, 3 = write pointer, 4 = control/status. Each address register keeps only write-data bits 47:0, and its bits 63:48 read as zero.
- R2: In the control/status register, bit 0 is enable, bit 1 is busy, bit 2 is terminated and bit 3 is protocol-error. The other bits read zero. After reset, all five registers read zero and no fetch, execute or interrupt output is active.
- R3: A control/status write with bit 0 = 1 sets enable and clears terminated and protocol-error. If the read pointer differs from the write pointer, busy rises two cycles after that write and stays set until every pending entry has completed. Busy then drops and enable stays set.
- R4: For each entry, `fetch_req` is high for one cycle with `fetch_addr` equal to the read pointer. The controller then takes eight `rsp_valid` beats in order, waiting through gaps. Word 0 appears on `exec_ctrl`, bits 47:0 of word 1 on `exec_src` and bits 47:0 of word 7 on `exec_dst`. `exec_valid` is held until `exec_done`.
- R5: `exec_bytes` equals control-word bits 15:0 plus one, including 0xFFFF giving 0x10000.
- R6: Each completion moves the read pointer forward by 0x40. When the read pointer equals the highest entry address, it goes to the lowest entry address instead.
- R7: When control-word bit 63 is set, `irq_pulse` is high for exactly the cycle after the completing `exec_done` cycle, with `irq_strand` equal to control-word bits 39:37. When bit 63 is clear, no pulse follows.
- R8: If, before a fetch, the read or write pointer has a nonzero value in bits 5:0, the controller sets protocol-error, clears busy and issues no fetch. A control/status write with bit 0 = 0 leaves protocol-error set.
- R9: A control/status write with bit 0 = 0 while busy lets the entry already in flight finish. Terminated is then set, busy drops and no further entry is fetched.
- R10: A software write to the read pointer while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |
| fetch_req | output | 1 | One-cycle request to read an entry |
| fetch_addr | output | 48 | Entry address of the request |
| rsp_valid | input | 1 | Entry word beat valid |
| rsp_data | input | 64 | Entry word beat data |
| exec_valid | output | 1 | Entry offered to the execution unit |
| exec_ctrl | output | 64 | Control word of the entry |
| exec_src | output | 48 | Source address |
| exec_dst | output | 48 | Destination address |
| exec_bytes | output | 17 | Operation length in bytes |
| exec_done | input | 1 | Execution unit finished the offered entry |
| irq_pulse | output | 1 | Completion interrupt pulse |
| irq_strand | output | 3 | Target strand of the interrupt |

## Verification
The bench sweeps every start position and every fill level of a four-entry ring. A controller that skipped the wrap from the highest entry to the lowest would fetch outside the ring, and one that stopped early or late would leave the wrong entry count or read pointer. Misaligned read and write pointers are offered and then repaired. A design that fetched anyway, or that cleared the error on a disable write, would show a stray fetch or a wrong status value. A stop issued while an entry is executing checks that exactly one entry completes, that terminated is raised, and that a read-pointer write made in the meantime is dropped. Inserted beat gaps, a slow execution unit and the maximum length code cover a capture that miscounts beats and an off-by-one length.

// File: rtl/dq_pkg.sv
package dq_pkg;

   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_LOW   = 3'd0,
      SEL_HIGH  = 3'd1,
      SEL_RDPTR = 3'd2,
      SEL_WRPTR = 3'd3,
      SEL_CSR   = 3'd4
   } dq_sel_e;

   localparam int NPTR = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_NEXT,
      ST_REQ,
      ST_RECV,
      ST_EXEC
   } dq_state_e;

endpackage

// File: rtl/dq_ptr_file.sv
module dq_ptr_file
   import dq_pkg::*;
#(
   parameter int ADDR_W      = 48,
   parameter int ENTRY_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              rd_lock,
   input  logic              rd_adv,
   output logic [ADDR_W-1:0] low_o,
   output logic [ADDR_W-1:0] high_o,
   output logic [ADDR_W-1:0] rd_o,
   output logic [ADDR_W-1:0] wr_o
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ENTRY_BYTES);

   logic [ADDR_W-1:0] rd_step;

   for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
      logic [ADDR_W-1:0] q;
      logic              hit;
      assign hit = wr_en && (wr_sel == SEL_W'(gi));
      if (gi == int'(SEL_RDPTR)) begin : g_rd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            q <= '0;
            else if (rd_adv)       q <= rd_step;
            else if (hit && !rd_lock) q <= wr_addr;
         end
      end else begin : g_sw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_addr;
         end
      end
   end

   assign low_o  = g_ptr[0].q;
   assign high_o = g_ptr[1].q;
   assign rd_o   = g_ptr[2].q;
   assign wr_o   = g_ptr[3].q;

   assign rd_step = (rd_o == high_o) ? low_o : rd_o + STEP;

endmodule

// File: rtl/dq_fetch.sv
module dq_fetch #(
   parameter int WORD_W      = 64,
   parameter int ADDR_W      = 48,
   parameter int ENTRY_WORDS = 8,
   parameter int SRC_IDX     = 1,
   parameter int DST_IDX     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              recv_en,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   output logic [WORD_W-1:0] ctrl_o,
   output logic [ADDR_W-1:0] src_o,
   output logic [ADDR_W-1:0] dst_o,
   output logic              last_o
);

   localparam int BEAT_W = (ENTRY_WORDS > 1) ? $clog2(ENTRY_WORDS) : 1;
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(ENTRY_WORDS - 1);
   localparam logic [BEAT_W-1:0] SRC_BEAT  = BEAT_W'(SRC_IDX);
   localparam logic [BEAT_W-1:0] DST_BEAT  = BEAT_W'(DST_IDX);

   logic [BEAT_W-1:0] beat_q;
   logic              take;

   assign take   = recv_en && rsp_valid;
   assign last_o = take && (beat_q == LAST_BEAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    beat_q <= '0;
      else if (take) beat_q <= last_o ? '0 : beat_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o <= '0;
         src_o  <= '0;
         dst_o  <= '0;
      end else if (take) begin
         if (beat_q == '0)      ctrl_o <= rsp_data;
         if (beat_q == SRC_BEAT) src_o <= rsp_data[ADDR_W-1:0];
         if (beat_q == DST_BEAT) dst_o <= rsp_data[ADDR_W-1:0];
      end
   end

endmodule

// File: rtl/dq_seq.sv
module dq_seq
   import dq_pkg::*;
#(
   parameter int ADDR_W   = 48,
   parameter int OFF_W    = 6,
   parameter int STRAND_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                csr_we,
   input  logic                csr_en_in,
   input  logic [ADDR_W-1:0]   rd_ptr,
   input  logic [ADDR_W-1:0]   wr_ptr,
   input  logic                fetch_last,
   input  logic                exec_done,
   input  logic                irq_flag,
   input  logic [STRAND_W-1:0] strand,
   output logic                fetch_req,
   output logic                recv_en,
   output logic                exec_valid,
   output logic                rd_adv,
   output logic                en_o,
   output logic                busy_o,
   output logic                term_o,
   output logic                perr_o,
   output logic                irq_o,
   output logic [STRAND_W-1:0] irq_strand_o
);

   dq_state_e st_q, st_d;
   logic      empty, misalign, done_hs;

   assign empty    = (rd_ptr == wr_ptr);
   assign misalign = (|rd_ptr[OFF_W-1:0]) || (|wr_ptr[OFF_W-1:0]);
   assign done_hs  = (st_q == ST_EXEC) && exec_done;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (en_o && !term_o && !perr_o && !empty) st_d = ST_NEXT;
         ST_NEXT: if (!en_o || empty || misalign) st_d = ST_IDLE;
                  else                            st_d = ST_REQ;
         ST_REQ:  st_d = ST_RECV;
         ST_RECV: if (fetch_last) st_d = ST_EXEC;
         ST_EXEC: if (exec_done) st_d = ST_NEXT;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= 1'b0;
         term_o <= 1'b0;
         perr_o <= 1'b0;
      end else begin
         if (st_q == ST_NEXT) begin
            if (!en_o)                  term_o <= 1'b1;
            else if (!empty && misalign) perr_o <= 1'b1;
         end
         if (csr_we) begin
            en_o <= csr_en_in;
            if (csr_en_in) begin
               term_o <= 1'b0;
               perr_o <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o        <= 1'b0;
         irq_strand_o <= '0;
      end else begin
         irq_o <= done_hs && irq_flag;
         if (done_hs) irq_strand_o <= strand;
      end
   end

   assign fetch_req  = (st_q == ST_REQ);
   assign recv_en    = (st_q == ST_RECV);
   assign exec_valid = (st_q == ST_EXEC);
   assign rd_adv     = done_hs;
   assign busy_o     = (st_q != ST_IDLE);

endmodule

// File: rtl/dq_ctrl.sv
module dq_ctrl
   import dq_pkg::*;
#(
   parameter int ADDR_W      = 48,
   parameter int WORD_W      = 64,
   parameter int ENTRY_WORDS = 8,
   parameter int STRAND_W    = 3,
   parameter int STRAND_LSB  = 37,
   parameter int IRQ_BIT     = 63,
   parameter int LEN_W       = 16,
   parameter int SRC_IDX     = 1,
   parameter int DST_IDX     = ENTRY_WORDS - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [SEL_W-1:0]    reg_sel,
   input  logic [WORD_W-1:0]   reg_wdata,
   output logic [WORD_W-1:0]   reg_rdata,
   output logic                fetch_req,
   output logic [ADDR_W-1:0]   fetch_addr,
   input  logic                rsp_valid,
   input  logic [WORD_W-1:0]   rsp_data,
   output logic                exec_valid,
   output logic [WORD_W-1:0]   exec_ctrl,
   output logic [ADDR_W-1:0]   exec_src,
   output logic [ADDR_W-1:0]   exec_dst,
   output logic [LEN_W:0]      exec_bytes,
   input  logic                exec_done,
   output logic                irq_pulse,
   output logic [STRAND_W-1:0] irq_strand
);

   localparam int ENTRY_BYTES = ENTRY_WORDS * WORD_W / 8;
   localparam int OFF_W       = $clog2(ENTRY_BYTES);

   if (ADDR_W > WORD_W) begin : g_bad_addr
      $error("address width exceeds word width");
   end
   if ((ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_entry
      $error("entry size must be a power of two");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_off
      $error("address width too small for entry alignment");
   end
   if (IRQ_BIT >= WORD_W || STRAND_LSB + STRAND_W > WORD_W || LEN_W > WORD_W) begin : g_bad_field
      $error("control word field outside the word");
   end
   if (SRC_IDX >= ENTRY_WORDS || DST_IDX >= ENTRY_WORDS || SRC_IDX == 0 || DST_IDX == 0) begin : g_bad_idx
      $error("address word index out of range");
   end

   logic [ADDR_W-1:0] ptr_low, ptr_high, ptr_rd, ptr_wr;
   logic              csr_en, csr_busy, csr_term, csr_perr;
   logic              rd_adv, recv_en, fetch_last, csr_we;

   assign csr_we = reg_we && (reg_sel == SEL_CSR);

   dq_ptr_file #(
      .ADDR_W      (ADDR_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_we),
      .wr_sel  (reg_sel),
      .wr_addr (reg_wdata[ADDR_W-1:0]),
      .rd_lock (csr_busy),
      .rd_adv  (rd_adv),
      .low_o   (ptr_low),
      .high_o  (ptr_high),
      .rd_o    (ptr_rd),
      .wr_o    (ptr_wr)
   );

   dq_fetch #(
      .WORD_W      (WORD_W),
      .ADDR_W      (ADDR_W),
      .ENTRY_WORDS (ENTRY_WORDS),
      .SRC_IDX     (SRC_IDX),
      .DST_IDX     (DST_IDX)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .recv_en   (recv_en),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .ctrl_o    (exec_ctrl),
      .src_o     (exec_src),
      .dst_o     (exec_dst),
      .last_o    (fetch_last)
   );

   dq_seq #(
      .ADDR_W   (ADDR_W),
      .OFF_W    (OFF_W),
      .STRAND_W (STRAND_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .csr_we       (csr_we),
      .csr_en_in    (reg_wdata[0]),
      .rd_ptr       (ptr_rd),
      .wr_ptr       (ptr_wr),
      .fetch_last   (fetch_last),
      .exec_done    (exec_done),
      .irq_flag     (exec_ctrl[IRQ_BIT]),
      .strand       (exec_ctrl[STRAND_LSB +: STRAND_W]),
      .fetch_req    (fetch_req),
      .recv_en      (recv_en),
      .exec_valid   (exec_valid),
      .rd_adv       (rd_adv),
      .en_o         (csr_en),
      .busy_o       (csr_busy),
      .term_o       (csr_term),
      .perr_o       (csr_perr),
      .irq_o        (irq_pulse),
      .irq_strand_o (irq_strand)
   );

   assign fetch_addr = ptr_rd;
   assign exec_bytes = (LEN_W+1)'(exec_ctrl[LEN_W-1:0]) + (LEN_W+1)'(1);

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_LOW:   reg_rdata[ADDR_W-1:0] = ptr_low;
         SEL_HIGH:  reg_rdata[ADDR_W-1:0] = ptr_high;
         SEL_RDPTR: reg_rdata[ADDR_W-1:0] = ptr_rd;
         SEL_WRPTR: reg_rdata[ADDR_W-1:0] = ptr_wr;
         SEL_CSR:   reg_rdata[3:0]        = {csr_perr, csr_term, csr_busy, csr_en};
         default:   reg_rdata             = '0;
      endcase
   end

endmodule

// File: rtl/dq_ctrl_chk.sv
module dq_ctrl_chk #(
   parameter int ADDR_W = 48,
   parameter int WORD_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_req,
   input logic              exec_valid,
   input logic              exec_done,
   input logic [WORD_W-1:0] exec_ctrl,
   input logic              irq_pulse,
   input logic [ADDR_W-1:0] rd_ptr,
   input logic              busy,
   input logic              term,
   input logic              perr
);

   // R4
   fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> !fetch_req);

   // R4
   exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && !exec_done) |=> (exec_valid && $stable(exec_ctrl)));

   // R7
   irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> $past(exec_valid && exec_done));

   // R3
   fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> busy);

   // R8
   perr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      perr |-> !busy);

   // R9
   term_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term |-> !fetch_req);

   // R10
   rd_ptr_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && !$stable(rd_ptr)) |-> $past(exec_valid && exec_done));

endmodule

bind dq_ctrl dq_ctrl_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fetch_req  (fetch_req),
   .exec_valid (exec_valid),
   .exec_done  (exec_done),
   .exec_ctrl  (exec_ctrl),
   .irq_pulse  (irq_pulse),
   .rd_ptr     (ptr_rd),
   .busy       (csr_busy),
   .term       (csr_term),
   .perr       (csr_perr)
);

// File: tb/dq_ctrl_tb.sv
module dq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        fetch_req;
   logic [47:0] fetch_addr;
   logic        rsp_valid = 1'b0;
   logic [63:0] rsp_data = '0;
   logic        exec_valid;
   logic [63:0] exec_ctrl;
   logic [47:0] exec_src, exec_dst;
   logic [16:0] exec_bytes;
   logic        exec_done = 1'b0;
   logic        irq_pulse;
   logic [2:0]  irq_strand;

   always #4 clk = ~clk;

   dq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
      .fetch_addr(fetch_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .exec_valid(exec_valid), .exec_ctrl(exec_ctrl), .exec_src(exec_src),
      .exec_dst(exec_dst), .exec_bytes(exec_bytes), .exec_done(exec_done),
      .irq_pulse(irq_pulse), .irq_strand(irq_strand)
   );

   int n_chk = 0, n_bad = 0, n_exec = 0, n_fetch = 0, n_irq = 0;
   int stub_delay = 2;
   logic [47:0] m_low, m_high, m_rd, cur_a;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   function automatic logic [47:0] step(input logic [47:0] a);
      return (a == m_high) ? m_low : a + 48'h40;
   endfunction

   function automatic logic [63:0] dword(input logic [47:0] a, input int k);
      logic [63:0] c;
      c = '0;
      if (k == 0) begin
         c[63]    = a[6] ^ a[8];
         c[62:56] = 7'h41;
         c[39:37] = a[9:7];
         c[15:0]  = (a[7:6] == 2'b11 && a[8]) ? 16'hFFFF : {a[13:6], 8'h1D};
      end else if (k == 1) c = {16'hABCD, a + 48'h100};
      else if (k == 7)     c = {16'h1234, ~a};
      else                 c = {a, 16'(k)};
      return c;
   endfunction

   task automatic wr(input logic [2:0] s, input logic [63:0] d);
      @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [63:0] d);
      @(negedge clk); reg_sel = s; #1 d = reg_rdata;
   endtask

   task automatic wait_idle;
      logic [63:0] v;
      for (int i = 0; i < 3000; i++) begin
         rd(3'd4, v);
         if (!v[1]) break;
      end
   endtask

   // memory responder: eight beats per request, with a gap on some entries
   initial begin
      forever begin
         @(negedge clk);
         if (fetch_req) begin
            cur_a = fetch_addr;
            n_fetch++;
            chk("R4/R6 fetch address", {16'h0, fetch_addr}, {16'h0, m_rd});
            m_rd = step(m_rd);
            @(negedge clk);
            for (int k = 0; k < 8; k++) begin
               if (k == 4 && cur_a[7]) begin rsp_valid = 1'b0; @(negedge clk); end
               rsp_valid = 1'b1; rsp_data = dword(cur_a, k);
               @(negedge clk);
            end
            rsp_valid = 1'b0;
         end
      end
   end

   // execution stub
   initial begin
      logic [63:0] c;
      forever begin
         @(negedge clk);
         if (exec_valid) begin
            c = dword(cur_a, 0);
            chk("R4 control word", exec_ctrl, c);
            chk("R4 source", {16'h0, exec_src}, {16'h0, dword(cur_a, 1)[47:0]});
            chk("R4 destination", {16'h0, exec_dst}, {16'h0, dword(cur_a, 7)[47:0]});
            chk("R5 byte count", 64'(exec_bytes), 64'(c[15:0]) + 64'd1);
            repeat (stub_delay) @(negedge clk);
            chk("R4 valid held", 64'(exec_valid), 64'd1);
            exec_done = 1'b1;
            @(negedge clk);
            exec_done = 1'b0;
            n_exec++;
            chk("R7 irq pulse", 64'(irq_pulse), 64'(c[63]));
            if (c[63]) begin
               n_irq++;
               chk("R7 irq strand", 64'(irq_strand), 64'(c[39:37]));
            end
            @(negedge clk);
            chk("R7 single pulse", 64'(irq_pulse), 64'd0);
         end
      end
   end

   task automatic run_ring(input logic [47:0] base, input int st, input int n);
      logic [47:0] h, t;
      logic [63:0] v;
      int e0;
      m_low = base; m_high = base + 48'hC0;
      h = base + 48'(st * 64); t = h;
      for (int i = 0; i < n; i++) t = step(t);
      wr(3'd0, {16'h0, m_low}); wr(3'd1, {16'h0, m_high});
      wr(3'd2, {16'h0, h});     wr(3'd3, {16'h0, t});
      m_rd = h; e0 = n_exec;
      wr(3'd4, 64'h1);
      rd(3'd4, v);
      chk("R3 busy after start", 64'(v[1]), 64'd1);
      wait_idle();
      rd(3'd4, v);
      chk("R3 status after drain", v, 64'h1);
      rd(3'd2, v);
      chk("R6 read pointer after drain", v, {16'h0, t});
      chk("R3 entries run", 64'(n_exec - e0), 64'(n));
      wr(3'd4, 64'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      logic [63:0] v;
      logic [47:0] base;
      int e0, f0;
      repeat (3) @(negedge clk);
      // R2: reset state
      for (int s = 0; s < 5; s++) begin
         rd(3'(s), v);
         chk("R2 reset register", v, 64'h0);
      end
      chk("R2 reset outputs", {61'h0, fetch_req, exec_valid, irq_pulse}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int s = 0; s < 5; s++) begin
         rd(3'(s), v);
         chk("R2 register after reset", v, 64'h0);
      end
      // R1: upper address bits dropped
      for (int s = 0; s < 4; s++) begin
         wr(3'(s), 64'hFFFF_1234_5678_9AC0 + 64'(s * 64));
         rd(3'(s), v);
         chk("R1 address readback", v, 64'h0000_1234_5678_9AC0 + 64'(s * 64));
      end
      wr(3'd2, 64'h0); wr(3'd3, 64'h0);
      rd(3'd5, v);
      chk("R1 unused select", v, 64'h0);

      // R3 R6 R7 R4 R5: every start position and fill level of a 4-entry ring
      for (int st = 0; st < 4; st++)
         for (int n = 1; n < 4; n++)
            run_ring(48'h0000_1234_0000 + 48'((st * 3 + n) * 256), st, n);
      chk("R7 some interrupts seen", 64'(n_irq > 0), 64'd1);

      // R8: misaligned write pointer, then misaligned read pointer
      base = 48'h0000_2000_0000;
      m_low = base; m_high = base + 48'hC0;
      wr(3'd0, {16'h0, m_low}); wr(3'd1, {16'h0, m_high});
      wr(3'd2, {16'h0, base}); wr(3'd3, {16'h0, base + 48'h48});
      f0 = n_fetch;
      wr(3'd4, 64'h1);
      repeat (6) @(negedge clk);
      rd(3'd4, v);
      chk("R8 error on misaligned write pointer", v, 64'h9);
      chk("R8 no fetch", 64'(n_fetch - f0), 64'd0);
      wr(3'd4, 64'h0);
      rd(3'd4, v);
      chk("R8 disable keeps error", v, 64'h8);
      wr(3'd2, {16'h0, base + 48'h8});
      wr(3'd3, {16'h0, base + 48'h40});
      wr(3'd4, 64'h1);
      repeat (6) @(negedge clk);
      rd(3'd4, v);
      chk("R8 error on misaligned read pointer", v, 64'h9);
      chk("R8 no fetch again", 64'(n_fetch - f0), 64'd0);
      wr(3'd4, 64'h0);
      wr(3'd2, {16'h0, base});
      m_rd = base; e0 = n_exec;
      wr(3'd4, 64'h1);
      wait_idle();
      rd(3'd4, v);
      chk("R8 recovered status", v, 64'h1);
      chk("R8 recovered entry", 64'(n_exec - e0), 64'd1);
      wr(3'd4, 64'h0);

      // R9 R10: stop while an entry executes
      stub_delay = 30;
      wr(3'd2, {16'h0, base});
      wr(3'd3, {16'h0, base + 48'hC0});
      m_rd = base; e0 = n_exec; f0 = n_fetch;
      wr(3'd4, 64'h1);
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (exec_valid) break;
      end
      wr(3'd2, 64'h0000_0BAD_0000);
      wr(3'd4, 64'h0);
      wait_idle();
      rd(3'd4, v);
      chk("R9 terminated status", v, 64'h4);
      chk("R9 one entry finished", 64'(n_exec - e0), 64'd1);
      chk("R9 no further fetch", 64'(n_fetch - f0), 64'd1);
      rd(3'd2, v);
      chk("R10 read pointer write ignored", v, {16'h0, base + 48'h40});
      stub_delay = 2;
      wr(3'd4, 64'h1);
      wait_idle();
      rd(3'd4, v);
      chk("R9 restart status", v, 64'h1);
      chk("R9 remaining entries", 64'(n_exec - e0), 64'd3);
      rd(3'd2, v);
      chk("R6 read pointer after restart", v, {16'h0, base + 48'hC0});
      finish_run();
   end

endmodule